// File: doc/BRIEF.md
# Converter Power Mode Sequencer

This block decides, cycle by cycle, whether the core of a sampling converter is powered, whether its on-chip reference is powered, and whether the core has had enough time to settle since it was last switched on. A 2-bit power-management code comes from the serial control register. Two single-cycle pulse inputs mark falling and rising serial clock edges. An active-low chip select frames each transfer. The block's own clock is the timebase that measures wake-up intervals.

A transfer ends on its sixteenth rising serial clock edge while chip select is low. At that point the code presented on the mode input becomes the active mode. There are four modes. Normal keeps everything on. Full shutdown turns everything off until normal is written again. Autoshutdown powers the core down at the end of each transfer and wakes it on the first falling serial edge of the next one. Autostandby behaves the same way but leaves the reference running, so the core wakes faster. The ready output tells the conversion logic when the wake-up interval has elapsed.

Top module: `pwr_mode_seq`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising clock edge), the active mode is normal and core_en_o, ref_en_o and ready_o are all high.
- R2: The mode codes are 2'b00 normal, 2'b01 full shutdown, 2'b10 autoshutdown and 2'b11 autostandby. The code on pm_field_i is taken only in the cycle in which the 16th rising serial edge pulse (sclk_rise_i) of a transfer arrives with cs_n_i low. The outputs reflect the new mode one clock later.
- R3: While the active mode is normal, core_en_o and ref_en_o stay high whatever cs_n_i, sclk_rise_i and sclk_fall_i do.
- R4: A transfer that ends with code 01 drives core_en_o and ref_en_o low. Serial edges in later transfers do not raise them while the mode stays 01.
- R5: A transfer that ends with code 00 while the core is off raises core_en_o one clock after the 16th rising edge. ready_o then stays low for DEEP_WAKE_US*CLK_MHZ cycles after a deep sleep, or for LIGHT_WAKE_US*CLK_MHZ cycles after a standby sleep or when ext_ref_i is high.
- R6: Writing code 10 while in full shutdown keeps the core off until the first falling serial edge of a later transfer.
- R7: In either auto mode, with the core off, the first sclk_fall_i pulse after cs_n_i falls raises core_en_o one clock later. Later falling edges in the same transfer do not restart the wake interval.
- R8: In either auto mode, the transfer's 16th rising edge drives core_en_o low one clock later, unless the code written in that transfer is 00.
- R9: In autoshutdown, ref_en_o equals core_en_o. A wake-up lasts DEEP_WAKE_US*CLK_MHZ cycles of ready_o low, or LIGHT_WAKE_US*CLK_MHZ cycles when ext_ref_i is high at the waking edge.
- R10: In autostandby, ref_en_o stays high while the core is off, and a wake-up lasts LIGHT_WAKE_US*CLK_MHZ cycles.
- R11: A mode written at the end of a transfer applies even during a wake-up count. Writing 00 while the core is already on lets the running count finish unchanged. Writing 01, 10 or 11 powers the core off and drops ready_o.
- R12: A transfer in which cs_n_i rises before the 16th rising edge leaves the mode unchanged. Serial edge pulses while cs_n_i is high have no effect.
- R13: ready_o is high only when core_en_o is high and the wake-up count has expired. It is low in the cycle after any power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock and wake-up timebase |
| rst_n | input | 1 | Synchronous active-low reset |
| pm_field_i | input | 2 | Power-management code from the control register |
| ext_ref_i | input | 1 | High when an external reference is fitted (short wake) |
| cs_n_i | input | 1 | Active-low chip select framing a transfer |
| sclk_rise_i | input | 1 | One-cycle pulse per rising serial clock edge |
| sclk_fall_i | input | 1 | One-cycle pulse per falling serial clock edge |
| core_en_o | output | 1 | Power enable for the converter core |
| ref_en_o | output | 1 | Power enable for the on-chip reference |
| ready_o | output | 1 | Core powered and wake-up interval elapsed |

## Verification
Every power and reference change appears one clock after the edge that samples the triggering serial pulse. ready_o stays low for exactly the configured number of cycles after that edge, then rises. The bench keeps a behavioural model that advances on each rising edge from the same inputs. It compares all three outputs with the model at every falling edge, so each result is checked in the cycle it is due. Directed checks also count the cycles in which the core is on but not ready, and compare that count with the wake interval the requirement names.

// File: rtl/pwrseq_pkg.sv
// Shared definitions for the power mode sequencer.
// Assumes the control register delivers the 2-bit code unchanged.
package pwrseq_pkg;

    typedef enum logic [1:0] {
        PM_NORMAL    = 2'b00,
        PM_FULL_OFF  = 2'b01,
        PM_AUTO_OFF  = 2'b10,
        PM_AUTO_STBY = 2'b11
    } pm_mode_e;

    // Converts a wake interval in microseconds to clock cycles.
    function automatic int unsigned us_to_cycles(input int unsigned mhz,
                                                 input int unsigned us);
        return mhz * us;
    endfunction

endpackage

// File: rtl/pwrseq_frame.sv
// Transfer tracker: counts rising serial edges while chip select is low.
// It flags the edge that completes a transfer and the first falling
// edge of a transfer.
// Assumes the edge pulses are one clock wide and never coincide.
module pwrseq_frame #(
    parameter int unsigned FRAME_EDGES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_i,
    input  logic sclk_rise_i,
    input  logic sclk_fall_i,
    output logic frame_end_o,
    output logic first_fall_o
);
    localparam int unsigned CW = $clog2(FRAME_EDGES + 1);

    logic [CW-1:0] rise_cnt_q;
    logic          fall_seen_q;

    // Decodes the completing rise and the first fall of the current transfer.
    always_comb begin
        frame_end_o  = !cs_n_i && sclk_rise_i && (rise_cnt_q == CW'(FRAME_EDGES - 1));
        first_fall_o = !cs_n_i && sclk_fall_i && !fall_seen_q;
    end

    // Keeps the per-transfer edge history and clears it while deselected.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n_i) begin
            rise_cnt_q  <= '0;
            fall_seen_q <= 1'b0;
        end else begin
            if (sclk_rise_i && rise_cnt_q != CW'(FRAME_EDGES))
                rise_cnt_q <= rise_cnt_q + CW'(1);
            if (sclk_fall_i)
                fall_seen_q <= 1'b1;
        end
    end

    AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_i |=> (rise_cnt_q == '0) && !fall_seen_q); // R12

    AST_SINGLE_END: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end_o |=> !frame_end_o); // R2

endmodule

// File: rtl/pwrseq_wake_timer.sv
// Wake-up interval counter. start loads the long or the short interval,
// clear abandons a count, and done is high whenever no count runs.
// Assumes start and clear are never high together.
module pwrseq_wake_timer #(
    parameter int unsigned LONG_CYC  = 625,
    parameter int unsigned SHORT_CYC = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic short_i,
    input  logic clear_i,
    output logic done_o
);
    localparam int unsigned MAX_CYC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
    localparam int unsigned CW      = $clog2(MAX_CYC + 1);

    logic [CW-1:0] cnt_q;

    // Loads, clears or counts down the remaining wake cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i)
            cnt_q <= '0;
        else if (start_i)
            cnt_q <= short_i ? CW'(SHORT_CYC) : CW'(LONG_CYC);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CW'(1);
    end

    // Reports that the interval has elapsed.
    always_comb done_o = (cnt_q == '0);

    AST_WAKE_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0 && !start_i && !clear_i) |=> (cnt_q == $past(cnt_q) - CW'(1))); // R9

    AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !clear_i) |=> !done_o); // R13

endmodule

// File: rtl/pwrseq_ctrl.sv
// Power state controller. It holds the active mode, the core and
// reference enables, and whether the last sleep was deep or standby.
// It requests wake timing from the timer.
// Assumes frame_end_i and first_fall_i are never high together.
module pwrseq_ctrl
    import pwrseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pm_field_i,
    input  logic       ext_ref_i,
    input  logic       frame_end_i,
    input  logic       first_fall_i,
    input  logic       timer_done_i,
    output logic       timer_start_o,
    output logic       timer_short_o,
    output logic       timer_clear_o,
    output logic       core_en_o,
    output logic       ref_en_o,
    output logic       ready_o
);
    pm_mode_e mode_q, mode_d;
    logic     core_q, core_d;
    logic     ref_q,  ref_d;
    logic     deep_q, deep_d;
    logic     auto_mode;

    // Works out the next power state from transfer events.
    always_comb begin
        mode_d        = mode_q;
        core_d        = core_q;
        ref_d         = ref_q;
        deep_d        = deep_q;
        timer_start_o = 1'b0;
        timer_short_o = 1'b0;
        timer_clear_o = 1'b0;
        auto_mode     = (mode_q == PM_AUTO_OFF) || (mode_q == PM_AUTO_STBY);
        if (frame_end_i) begin
            mode_d = pm_mode_e'(pm_field_i);
            case (pm_mode_e'(pm_field_i))
                PM_NORMAL: begin
                    ref_d = 1'b1;
                    if (!core_q) begin
                        core_d        = 1'b1;
                        timer_start_o = 1'b1;
                        timer_short_o = ext_ref_i || !deep_q;
                    end
                end
                PM_AUTO_STBY: begin
                    core_d        = 1'b0;
                    ref_d         = 1'b1;
                    deep_d        = 1'b0;
                    timer_clear_o = 1'b1;
                end
                default: begin
                    core_d        = 1'b0;
                    ref_d         = 1'b0;
                    deep_d        = 1'b1;
                    timer_clear_o = 1'b1;
                end
            endcase
        end else if (first_fall_i && auto_mode && !core_q) begin
            core_d        = 1'b1;
            ref_d         = 1'b1;
            timer_start_o = 1'b1;
            timer_short_o = ext_ref_i || (mode_q == PM_AUTO_STBY);
        end
    end

    // Registers the power state; reset brings the part up in normal mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= PM_NORMAL;
            core_q <= 1'b1;
            ref_q  <= 1'b1;
            deep_q <= 1'b1;
        end else begin
            mode_q <= mode_d;
            core_q <= core_d;
            ref_q  <= ref_d;
            deep_q <= deep_d;
        end
    end

    // Drives the enables and the ready flag.
    always_comb begin
        core_en_o = core_q;
        ref_en_o  = ref_q;
        ready_o   = core_q && timer_done_i;
    end

    AST_NORMAL_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PM_NORMAL) |-> (core_q && ref_q)); // R3

    AST_FULL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PM_FULL_OFF) |-> (!core_q && !ref_q)); // R4

    AST_STBY_REF: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PM_AUTO_STBY) |-> ref_q); // R10

    AST_AUTO_OFF_REF: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PM_AUTO_OFF) |-> (ref_q == core_q)); // R9

    AST_MODE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end_i |=> $stable(mode_q)); // R2

endmodule

// File: rtl/pwr_mode_seq.sv
// Top of the power mode sequencer: the transfer tracker feeds the
// controller, and the controller drives the wake timer.
// Assumes one clock per timebase tick, with CLK_MHZ clock cycles per microsecond.
module pwr_mode_seq
    import pwrseq_pkg::*;
#(
    parameter int unsigned CLK_MHZ       = 125,
    parameter int unsigned DEEP_WAKE_US  = 5,
    parameter int unsigned LIGHT_WAKE_US = 1,
    parameter int unsigned FRAME_EDGES   = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pm_field_i,
    input  logic       ext_ref_i,
    input  logic       cs_n_i,
    input  logic       sclk_rise_i,
    input  logic       sclk_fall_i,
    output logic       core_en_o,
    output logic       ref_en_o,
    output logic       ready_o
);
    localparam int unsigned LONG_CYC  = us_to_cycles(CLK_MHZ, DEEP_WAKE_US);
    localparam int unsigned SHORT_CYC = us_to_cycles(CLK_MHZ, LIGHT_WAKE_US);

    logic frame_end, first_fall;
    logic t_start, t_short, t_clear, t_done;

    pwrseq_frame #(.FRAME_EDGES(FRAME_EDGES)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n_i      (cs_n_i),
        .sclk_rise_i (sclk_rise_i),
        .sclk_fall_i (sclk_fall_i),
        .frame_end_o (frame_end),
        .first_fall_o(first_fall)
    );

    pwrseq_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .pm_field_i   (pm_field_i),
        .ext_ref_i    (ext_ref_i),
        .frame_end_i  (frame_end),
        .first_fall_i (first_fall),
        .timer_done_i (t_done),
        .timer_start_o(t_start),
        .timer_short_o(t_short),
        .timer_clear_o(t_clear),
        .core_en_o    (core_en_o),
        .ref_en_o     (ref_en_o),
        .ready_o      (ready_o)
    );

    pwrseq_wake_timer #(.LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(t_start),
        .short_i(t_short),
        .clear_i(t_clear),
        .done_o (t_done)
    );

    AST_POWERUP_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_en_o) |-> !ready_o); // R13

    AST_OFF_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !core_en_o |-> !ready_o); // R13

endmodule

// File: tb/tb_pwr_mode_seq.sv
module tb_pwr_mode_seq;
    localparam int CLK_MHZ = 125;
    localparam int LONG    = CLK_MHZ * 5;
    localparam int SHORT   = CLK_MHZ * 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] pm_field = 2'b00;
    logic ext_ref = 1'b0, cs_n = 1'b1, sclk_rise = 1'b0, sclk_fall = 1'b0;
    logic core_en, ref_en, ready;

    int checks = 0, errors = 0;
    int lowcnt = 0;
    logic snap_core = 1'b0;
    bit   comparing = 1'b0, finished = 1'b0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    pwr_mode_seq dut (
        .clk(clk), .rst_n(rst_n), .pm_field_i(pm_field), .ext_ref_i(ext_ref),
        .cs_n_i(cs_n), .sclk_rise_i(sclk_rise), .sclk_fall_i(sclk_fall),
        .core_en_o(core_en), .ref_en_o(ref_en), .ready_o(ready)
    );

    // Behavioural reference model
    int m_mode, m_core, m_ref, m_deep, m_cnt, m_rises, m_fell;
    always @(posedge clk) begin
        bit fe, ff;
        if (!rst_n) begin
            m_mode = 0; m_core = 1; m_ref = 1; m_deep = 1; m_cnt = 0; m_rises = 0; m_fell = 0;
        end else begin
            fe = !cs_n && sclk_rise && (m_rises == 15);
            ff = !cs_n && sclk_fall && (m_fell == 0);
            if (cs_n) begin m_rises = 0; m_fell = 0; end
            else begin
                if (sclk_rise && m_rises < 16) m_rises++;
                if (sclk_fall) m_fell = 1;
            end
            if (m_cnt > 0) m_cnt--;
            if (fe) begin
                m_mode = int'(pm_field);
                if (m_mode == 0) begin
                    m_ref = 1;
                    if (m_core == 0) begin
                        m_core = 1;
                        m_cnt = (ext_ref || m_deep == 0) ? SHORT : LONG;
                    end
                end else begin
                    m_core = 0; m_cnt = 0;
                    m_ref  = (m_mode == 3) ? 1 : 0;
                    m_deep = (m_mode == 3) ? 0 : 1;
                end
            end else if (ff && m_mode >= 2 && m_core == 0) begin
                m_core = 1; m_ref = 1;
                m_cnt = (ext_ref || m_mode == 3) ? SHORT : LONG;
            end
        end
    end

    // Wake interval measurement: cycles with core on and not ready
    always @(posedge clk) if (core_en && !ready) lowcnt++;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (comparing) begin
            chk(cur_req, "core_en cycle", int'(core_en), m_core);
            chk(cur_req, "ref_en cycle", int'(ref_en), m_ref);
            chk(cur_req, "ready cycle", int'(ready), (m_core == 1 && m_cnt == 0) ? 1 : 0);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_frame(input logic [1:0] pm, input int nbits, input logic ext);
        @(negedge clk);
        cs_n = 1'b0; pm_field = pm; ext_ref = ext; lowcnt = 0;
        for (int b = 0; b < nbits; b++) begin
            @(negedge clk) sclk_fall = 1'b1;
            @(negedge clk) sclk_fall = 1'b0;
            if (b == 0) snap_core = core_en;
            @(negedge clk) sclk_rise = 1'b1;
            @(negedge clk) sclk_rise = 1'b0;
        end
        @(negedge clk) cs_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        comparing = 1'b1;
        cur_req = "R1";
        chk("R1", "core_en after reset", int'(core_en), 1);
        chk("R1", "ref_en after reset", int'(ref_en), 1);
        chk("R1", "ready after reset", int'(ready), 1);

        cur_req = "R3";
        do_frame(2'b00, 16, 1'b0);
        chk("R3", "core_en in normal", int'(core_en), 1);
        chk("R3", "ready in normal", int'(ready), 1);

        cur_req = "R4";
        do_frame(2'b01, 16, 1'b0);
        chk("R4", "core_en full off", int'(core_en), 0);
        chk("R4", "ref_en full off", int'(ref_en), 0);
        do_frame(2'b01, 16, 1'b0);
        chk("R4", "no wake on first fall", int'(snap_core), 0);

        cur_req = "R5";
        do_frame(2'b00, 16, 1'b0);
        chk("R5", "core_en after exit", int'(core_en), 1);
        idle(LONG + 5);
        chk("R5", "long wake cycles", lowcnt, LONG);

        cur_req = "R6";
        do_frame(2'b01, 16, 1'b0);
        do_frame(2'b10, 16, 1'b0);
        chk("R6", "stays off after code 10", int'(core_en), 0);

        cur_req = "R7";
        do_frame(2'b10, 16, 1'b0);
        chk("R7", "first fall wakes", int'(snap_core), 1);
        cur_req = "R8";
        chk("R8", "down at 16th rise", int'(core_en), 0);
        chk("R9", "ref follows core", int'(ref_en), 0);

        cur_req = "R9";
        do_frame(2'b00, 16, 1'b0);
        idle(LONG + 5);
        chk("R9", "autoshutdown long wake", lowcnt, LONG);
        do_frame(2'b10, 16, 1'b0);
        do_frame(2'b00, 16, 1'b1);
        idle(LONG + 5);
        chk("R9", "external reference short wake", lowcnt, SHORT);
        ext_ref = 1'b0;

        cur_req = "R10";
        do_frame(2'b11, 16, 1'b0);
        chk("R10", "core off in standby", int'(core_en), 0);
        chk("R10", "ref on in standby", int'(ref_en), 1);
        do_frame(2'b00, 16, 1'b0);
        idle(LONG + 5);
        chk("R10", "standby short wake", lowcnt, SHORT);

        cur_req = "R11";
        do_frame(2'b01, 16, 1'b0);
        do_frame(2'b00, 16, 1'b0);
        chk("R11", "waking not ready", int'(ready), 0);
        do_frame(2'b10, 16, 1'b0);
        chk("R11", "mode applied mid wake core", int'(core_en), 0);
        chk("R11", "mode applied mid wake ready", int'(ready), 0);
        do_frame(2'b11, 16, 1'b0);
        chk("R11", "standby after wake cut", int'(ref_en), 1);

        cur_req = "R12";
        do_frame(2'b01, 3, 1'b0);
        chk("R12", "aborted frame woke core", int'(core_en), 1);
        @(negedge clk) sclk_rise = 1'b1;
        @(negedge clk) sclk_rise = 1'b0; sclk_fall = 1'b1;
        @(negedge clk) sclk_fall = 1'b0;
        @(negedge clk);
        chk("R12", "deselected edges ignored", int'(core_en), 1);
        do_frame(2'b11, 16, 1'b0);
        chk("R12", "mode kept after abort", int'(ref_en), 1);
        chk("R12", "core down at end", int'(core_en), 0);

        cur_req = "R13";
        do_frame(2'b00, 16, 1'b0);
        chk("R13", "not ready right after wake", int'(ready), 0);
        idle(SHORT + 5);
        chk("R13", "ready after wake", int'(ready), 1);

        comparing = 1'b0;
        finished = 1'b1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (150000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule